// File: doc/BRIEF.md
# Two-Wire Bus Packet Error Check Engine

This block keeps a running 8-bit CRC over every byte that crosses a two-wire serial bus in one message. The address byte, with its read/write bit, counts as a message byte. The bus controller reports each completed byte on a one-cycle strobe, together with the current direction and whether the controller is the bus master. Bit-level bus signalling is handled elsewhere.

When the controller transmits, a request from software, or a transmit end-of-transfer from a DMA channel, marks the next byte slot as the CRC byte. The engine presents the value to send on `crc_out` and raises `pec_send` until that byte goes out. When the controller receives, a request from software, or an early end-of-transfer from the DMA channel, marks the next received byte as the CRC to check. In that byte's cycle the engine drives `nack_req`, which tells the controller whether to refuse the byte.

A mismatch sets a sticky error flag, and only software clears it. A master receiver refuses the CRC byte whatever the check result when the request came from software, or when the DMA request was flagged as the last one. An arbitration loss makes the running CRC unusable until the next start condition.

Top module: `pec_engine`

## Requirements
- R1: On each `byte_valid` strobe that is not a CRC byte slot, `crc_out` becomes CRC-8 (polynomial 0x07, most significant bit first, no final inversion) of the previous `crc_out` and `byte_data`, one cycle later. For example, the ASCII bytes "123456789" taken from zero give 0xF4.
- R2: After reset, and one cycle after a `start_det` pulse, `crc_out` is 0x00 and `crc_valid` is 1, and nothing is armed.
- R3: While `pec_en` is 0, `crc_out` stays at 0x00. Bytes, requests and end-of-transfer inputs have no effect, and `pec_send`, `pec_expect` and `nack_req` stay 0.
- R4: In transmit mode (`is_tx`=1), `pec_req` raises `pec_send` on the next cycle. The next `byte_valid` lowers it, and that byte does not change `crc_out`.
- R5: In transmit mode, `dma_eot` raises `pec_send` only while `dma_en` is 1.
- R6: In receive mode, `pec_req` (or `dma_eot_early` with `dma_en`=1) raises `pec_expect`. If the next byte differs from `crc_out`, `nack_req` is 1 during that byte's strobe cycle and `pec_err` is 1 from the following cycle.
- R7: A slave receiver whose CRC byte matches sees `nack_req` at 0 and `pec_err` unchanged.
- R8: A master receiver (`is_master`=1) armed by `pec_req` sees `nack_req` at 1 on the CRC byte even when the byte matches.
- R9: A master receiver armed by `dma_eot_early` refuses a matching CRC byte only if `last_bit` was 1 when it was armed. A mismatching CRC byte is refused either way.
- R10: `arb_lost` drops `crc_valid` to 0 and disarms the engine. Until the next `start_det`, bytes leave `crc_out` unchanged and requests arm nothing.
- R11: `pec_err` holds until `err_clr`, and `err_clr` wins over a mismatch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pec_en | input | 1 | Enables the engine |
| start_det | input | 1 | Start condition seen on the bus |
| is_tx | input | 1 | 1 when this side transmits bytes |
| is_master | input | 1 | 1 when this side is the bus master |
| byte_valid | input | 1 | One-cycle strobe: a byte completed on the bus |
| byte_data | input | 8 | Byte sent or received |
| pec_req | input | 1 | Software request: next byte slot is the CRC |
| dma_en | input | 1 | DMA channel drives the transfer |
| dma_eot | input | 1 | Transmit end-of-transfer from the DMA channel |
| dma_eot_early | input | 1 | Receive early end-of-transfer from the DMA channel |
| last_bit | input | 1 | Current DMA request is the final one |
| arb_lost | input | 1 | Arbitration lost on the bus |
| err_clr | input | 1 | Clears the error flag |
| crc_out | output | 8 | Running CRC, which is also the byte to transmit |
| crc_valid | output | 1 | Running CRC is usable |
| pec_send | output | 1 | Next transmitted byte must be the CRC |
| pec_expect | output | 1 | Next received byte is the CRC to check |
| nack_req | output | 1 | Refuse the byte on the current strobe |
| pec_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The CRC itself is driven with the standard nine-digit check string and with a mixed message that starts with an address byte. The first ties the output to the polynomial and the bit order, and the second shows that the address byte is folded in. Receive checks combine a matching and a corrupted CRC byte with slave, software-armed master and DMA-armed master (with and without the last flag). This separates refusals caused by a mismatch from refusals that the master role forces. Disabled-mode and arbitration-loss runs feed bytes and requests that must leave every output untouched.

// File: rtl/pec_pkg.sv
// Shared constants and the bitwise CRC step for the packet error check engine.
// Assumes an 8-bit CRC with no reflection and no output inversion.
package pec_pkg;
    localparam int          PEC_W    = 8;
    localparam logic [PEC_W-1:0] PEC_POLY = 8'h07;

    // Folds one byte into a CRC, most significant bit first.
    function automatic logic [PEC_W-1:0] crc_fold(input logic [PEC_W-1:0] crc_in,
                                                  input logic [PEC_W-1:0] data);
        logic [PEC_W-1:0] c;
        c = crc_in;
        for (int i = PEC_W - 1; i >= 0; i--) begin
            if (c[PEC_W-1] ^ data[i])
                c = (c << 1) ^ PEC_POLY;
            else
                c = c << 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/pec_crc_reg.sv
// Running CRC register with its validity bit.
// Assumes 'fold' is raised only for message bytes, never for the CRC byte.
module pec_crc_reg #(
    parameter int W = pec_pkg::PEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic         arb_lost,
    input  logic         fold,
    input  logic [W-1:0] data,
    output logic [W-1:0] crc,
    output logic         valid
);
    // Clears on start or disable, invalidates on arbitration loss, else folds bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || start) begin
            crc   <= '0;
            valid <= 1'b1;
        end else if (arb_lost) begin
            valid <= 1'b0;
        end else if (fold && valid) begin
            crc <= pec_pkg::crc_fold(crc, data);
        end
    end

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start) |=> (crc == '0 && valid));
    assert_disabled_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (crc == '0));
    assert_arb_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && arb_lost) |=> !valid);
    assert_invalid_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && !valid) |=> $stable(crc));
endmodule

// File: rtl/pec_arm_ctl.sv
// Decides which byte slot carries the CRC and whether a received CRC byte is refused.
// Assumes byte_valid is a one-cycle strobe per completed byte.
module pec_arm_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic arb_lost,
    input  logic crc_ok,
    input  logic is_tx,
    input  logic is_master,
    input  logic pec_req,
    input  logic dma_en,
    input  logic dma_eot,
    input  logic dma_eot_early,
    input  logic last_bit,
    input  logic byte_valid,
    input  logic mismatch,
    output logic send_q,
    output logic expect_q,
    output logic nack_req,
    output logic chk_fail
);
    logic force_q;
    logic arm_tx;
    logic arm_rx;
    logic live;
    logic chk_now;

    // Qualifies arming requests against the current mode and CRC validity.
    always_comb begin
        live    = en && crc_ok && !start && !arb_lost;
        arm_tx  = live && is_tx && (pec_req || (dma_en && dma_eot));
        arm_rx  = live && !is_tx && (pec_req || (dma_en && dma_eot_early));
        chk_now = live && expect_q && byte_valid;
    end

    // Holds the armed slot and the forced-refusal choice made when arming.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || start || arb_lost) begin
            send_q   <= 1'b0;
            expect_q <= 1'b0;
            force_q  <= 1'b0;
        end else begin
            if (byte_valid) begin
                send_q   <= 1'b0;
                expect_q <= 1'b0;
                force_q  <= 1'b0;
            end
            if (arm_tx)
                send_q <= 1'b1;
            if (arm_rx) begin
                expect_q <= 1'b1;
                force_q  <= is_master && (pec_req || last_bit);
            end
        end
    end

    // Refuses the CRC byte on a mismatch or when the master role demands it.
    always_comb begin
        nack_req = chk_now && (force_q || mismatch);
        chk_fail = chk_now && mismatch;
    end

    assert_send_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (send_q && byte_valid && !arm_tx) |=> !send_q);
    assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!send_q && !expect_q));
    assert_arb_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> (!send_q && !expect_q));
    assert_one_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_q, expect_q}));
endmodule

// File: rtl/pec_err_flag.sv
// Sticky CRC mismatch flag. Assumes clear has priority over set.
module pec_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Latches a mismatch until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
    end

    assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/pec_engine.sv
// Packet error check engine for a two-wire bus controller.
// Assumes the controller reports each completed byte, direction and master role.
module pec_engine #(
    parameter int W = pec_pkg::PEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pec_en,
    input  logic         start_det,
    input  logic         is_tx,
    input  logic         is_master,
    input  logic         byte_valid,
    input  logic [W-1:0] byte_data,
    input  logic         pec_req,
    input  logic         dma_en,
    input  logic         dma_eot,
    input  logic         dma_eot_early,
    input  logic         last_bit,
    input  logic         arb_lost,
    input  logic         err_clr,
    output logic [W-1:0] crc_out,
    output logic         crc_valid,
    output logic         pec_send,
    output logic         pec_expect,
    output logic         nack_req,
    output logic         pec_err
);
    logic fold;
    logic mismatch;
    logic chk_fail;

    // Message bytes are folded; the CRC byte slot itself is not.
    always_comb begin
        fold     = byte_valid && !pec_send && !pec_expect;
        mismatch = (byte_data != crc_out);
    end

    pec_crc_reg #(.W(W)) u_crc (
        .clk(clk), .rst_n(rst_n), .en(pec_en), .start(start_det),
        .arb_lost(arb_lost), .fold(fold), .data(byte_data),
        .crc(crc_out), .valid(crc_valid)
    );

    pec_arm_ctl u_arm (
        .clk(clk), .rst_n(rst_n), .en(pec_en), .start(start_det),
        .arb_lost(arb_lost), .crc_ok(crc_valid), .is_tx(is_tx),
        .is_master(is_master), .pec_req(pec_req), .dma_en(dma_en),
        .dma_eot(dma_eot), .dma_eot_early(dma_eot_early), .last_bit(last_bit),
        .byte_valid(byte_valid), .mismatch(mismatch),
        .send_q(pec_send), .expect_q(pec_expect),
        .nack_req(nack_req), .chk_fail(chk_fail)
    );

    pec_err_flag u_err (
        .clk(clk), .rst_n(rst_n), .set(chk_fail), .clr(err_clr), .flag(pec_err)
    );

    assert_no_nack_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pec_en |-> !nack_req);
    assert_tx_byte_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_en && !start_det && !arb_lost && pec_send && byte_valid) |=> $stable(crc_out));
endmodule

// File: tb/pec_engine_bench.sv
`timescale 1ns/1ps
module pec_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pec_en = 1'b0, start_det = 1'b0, is_tx = 1'b0, is_master = 1'b0;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic pec_req = 1'b0, dma_en = 1'b0, dma_eot = 1'b0, dma_eot_early = 1'b0;
    logic last_bit = 1'b0, arb_lost = 1'b0, err_clr = 1'b0;
    logic [7:0] crc_out;
    logic crc_valid, pec_send, pec_expect, nack_req, pec_err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model = 8'h00;
    logic seen_nack;

    always #2.5 clk = ~clk;

    pec_engine u_pec_engine (
        .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .start_det(start_det),
        .is_tx(is_tx), .is_master(is_master), .byte_valid(byte_valid),
        .byte_data(byte_data), .pec_req(pec_req), .dma_en(dma_en),
        .dma_eot(dma_eot), .dma_eot_early(dma_eot_early), .last_bit(last_bit),
        .arb_lost(arb_lost), .err_clr(err_clr), .crc_out(crc_out),
        .crc_valid(crc_valid), .pec_send(pec_send), .pec_expect(pec_expect),
        .nack_req(nack_req), .pec_err(pec_err)
    );

    // Reference CRC: polynomial division of the 16-bit word {crc^data, 0}.
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = {c ^ d, 8'h00};
        for (int k = 15; k >= 8; k--)
            if (r[k]) r = r ^ (16'h0107 << (k - 8));
        return r[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_start();
        @(negedge clk); start_det = 1'b1; tick(); start_det = 1'b0; model = 8'h00;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        #1 seen_nack = nack_req;
        tick(); byte_valid = 1'b0;
    endtask

    task automatic msg_byte(input logic [7:0] b);
        do_byte(b); model = ref_crc(model, b);
    endtask

    task automatic do_req();
        @(negedge clk); pec_req = 1'b1; tick(); pec_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 reset crc", crc_out, 8'h00);
        check("R2 reset valid", {7'b0, crc_valid}, 8'h01);
        check("R2 reset armed", {6'b0, pec_send, pec_expect}, 8'h00);
        check("R11 reset err", {7'b0, pec_err}, 8'h00);
    endtask

    task automatic t_crc_vector();
        string s = "123456789";
        do_start();
        foreach (s[i]) msg_byte(s[i]);
        check("R1 check string", crc_out, 8'hF4);
        do_start();
        msg_byte(8'hA5); msg_byte(8'h00); msg_byte(8'hFF); msg_byte(8'h3C);
        check("R1 address plus data", crc_out, model);
        do_start();
        check("R2 start clears", crc_out, 8'h00);
    endtask

    task automatic t_disabled();
        @(negedge clk); pec_en = 1'b0;
        do_byte(8'h5A); is_tx = 1'b1; do_req();
        check("R3 crc idle", crc_out, 8'h00);
        check("R3 no arm", {6'b0, pec_send, pec_expect}, 8'h00);
        is_tx = 1'b0; do_req(); do_byte(8'h11);
        check("R3 no nack", {7'b0, seen_nack}, 8'h00);
        check("R3 no err", {7'b0, pec_err}, 8'h00);
        @(negedge clk); pec_en = 1'b1;
    endtask

    task automatic t_tx();
        logic [7:0] held;
        is_tx = 1'b1; do_start();
        msg_byte(8'h48); msg_byte(8'h21);
        do_req();
        check("R4 send armed", {7'b0, pec_send}, 8'h01);
        held = crc_out;
        do_byte(held);
        check("R4 send cleared", {7'b0, pec_send}, 8'h00);
        check("R4 crc held", crc_out, held);
        dma_en = 1'b0; @(negedge clk); dma_eot = 1'b1; tick(); dma_eot = 1'b0;
        check("R5 eot ignored without dma", {7'b0, pec_send}, 8'h00);
        dma_en = 1'b1; @(negedge clk); dma_eot = 1'b1; tick(); dma_eot = 1'b0;
        check("R5 eot arms send", {7'b0, pec_send}, 8'h01);
        do_byte(crc_out); dma_en = 1'b0; is_tx = 1'b0;
    endtask

    task automatic t_rx();
        is_master = 1'b0; do_start();
        msg_byte(8'h91); msg_byte(8'h07);
        do_req();
        check("R6 expect armed", {7'b0, pec_expect}, 8'h01);
        do_byte(model ^ 8'h01);
        check("R6 nack on mismatch", {7'b0, seen_nack}, 8'h01);
        check("R6 err set", {7'b0, pec_err}, 8'h01);
        tick();
        check("R11 err sticky", {7'b0, pec_err}, 8'h01);
        @(negedge clk); err_clr = 1'b1; tick(); err_clr = 1'b0;
        check("R11 err cleared", {7'b0, pec_err}, 8'h00);
        do_start(); msg_byte(8'h33); do_req();
        @(negedge clk); byte_valid = 1'b1; byte_data = ~model; err_clr = 1'b1;
        tick(); byte_valid = 1'b0; err_clr = 1'b0;
        check("R11 clear wins", {7'b0, pec_err}, 8'h00);
        do_start(); msg_byte(8'h62); do_req(); do_byte(model);
        check("R7 slave match no nack", {7'b0, seen_nack}, 8'h00);
        check("R7 slave match no err", {7'b0, pec_err}, 8'h00);
        is_master = 1'b1; do_start(); msg_byte(8'hC3); do_req(); do_byte(model);
        check("R8 master forced nack", {7'b0, seen_nack}, 8'h01);
        check("R8 no err on match", {7'b0, pec_err}, 8'h00);
    endtask

    task automatic t_dma_rx(input logic last, input logic corrupt, input logic exp_nack);
        is_master = 1'b1; dma_en = 1'b1; do_start(); msg_byte(8'h17); msg_byte(8'hE2);
        @(negedge clk); dma_eot_early = 1'b1; last_bit = last; tick();
        dma_eot_early = 1'b0; last_bit = 1'b0;
        check("R9 expect armed", {7'b0, pec_expect}, 8'h01);
        do_byte(corrupt ? ~model : model);
        check("R9 nack choice", {7'b0, seen_nack}, {7'b0, exp_nack});
        @(negedge clk); err_clr = 1'b1; tick(); err_clr = 1'b0; dma_en = 1'b0;
    endtask

    task automatic t_arb();
        logic [7:0] held;
        is_tx = 1'b1; do_start(); msg_byte(8'h4D);
        @(negedge clk); arb_lost = 1'b1; tick(); arb_lost = 1'b0;
        check("R10 invalid", {7'b0, crc_valid}, 8'h00);
        held = crc_out;
        do_byte(8'h99); do_req();
        check("R10 crc frozen", crc_out, held);
        check("R10 no arm", {7'b0, pec_send}, 8'h00);
        do_start();
        check("R10 start restores", {7'b0, crc_valid}, 8'h01);
        is_tx = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        @(negedge clk); rst_n = 1'b1; pec_en = 1'b1;
        tick();
        t_reset();
        t_crc_vector();
        t_disabled();
        t_tx();
        t_rx();
        t_dma_rx(1'b1, 1'b0, 1'b1);
        t_dma_rx(1'b0, 1'b0, 1'b0);
        t_dma_rx(1'b0, 1'b1, 1'b1);
        t_arb();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule